// File: doc/BRIEF.md
# Receive Packet Payload Realigner

This block sits on a 256-bit receive stream that carries transaction-layer packets, eight 32-bit dwords per beat, with dword 0 in bits 31:0. Each packet opens with a 3-dword or 4-dword header in the low dwords of its first beat. The payload follows in the same beat. Depending on header size and address bit 2, the payload may sit behind a one-dword gap. The block splits the header off onto a separate header port. It then shifts the payload so that payload dword 0 always lands in output dword 0. Dwords that straddle input beats are carried forward, and the end-of-packet empty count is rebuilt in dword units.

The payload length comes from the first header dword, so the output beat count does not depend on the input empty field. When the last input beat leaves payload dwords that do not fit in the output beat it produces, one more output beat is sent from stored data alone. The input is stalled during that beat. One packet per beat is handled. The header is released on its own handshake before any payload beat of the same packet.

Top module: `tlp_rx_realign`

## Requirements
- R1: An input beat transfers only on a cycle with in_valid and in_ready both high, and an output beat only with out_valid and out_ready both high. While out_valid is high and out_ready low, out_valid, out_data, out_eop and out_empty keep their values.
- R2: For each packet, hdr_data presents dwords 0..2 of the first beat in bits 95:0. Bits 127:96 carry dword 3 when hdr_4dw is 1 and are zero otherwise. hdr_4dw equals bit 29 of header dword 0. Both hold under hdr_valid until hdr_ready.
- R3: No payload beat of a packet is presented on the output before that packet's header has been taken on the header port.
- R4: The first payload dword is read from input dword 4 for a 3-dword header with bit 2 of header dword 2 clear, and from dword 3 when that bit is set. For a 4-dword header it is read from dword 4 with bit 2 of header dword 3 clear, and from dword 5 when that bit is set. It always appears in output dword 0.
- R5: Payload dwords appear on the output consecutively, eight per beat, across input beat boundaries.
- R6: The payload length L is bits 9:0 of header dword 0, with 0 meaning 1024. A packet yields ceil(L/8) output beats, with out_sop on the first and out_eop on the last. The input is expected to raise in_eop on exactly the beat holding the last payload dword, with in_empty giving the number of wholly unused 64-bit pairs of dwords above the last used dword.
- R7: On the out_eop beat, out_empty (3 bits) equals (8 - L mod 8) mod 8, and the unused upper dwords are zero. On every other beat out_empty is 0.
- R8: When the final input beat still holds payload that its own output beat does not cover, one further output beat is produced from stored data without any new input beat.
- R9: A packet whose start and end fall on the same input beat is handled like any other.
- R10: A beat accepted while no packet is in progress and without in_sop is discarded and produces no output.
- R11: in_ready is low while a packet is in progress and the output register is full and not being drained.
- R12: After reset, out_valid and hdr_valid are 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 256 | Input beat, dword 0 in bits 31:0 |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_empty | input | 2 | Unused 64-bit pairs on the last beat |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Block accepts the input beat |
| hdr_data | output | 128 | Header dwords 0..3 |
| hdr_4dw | output | 1 | Header is 4 dwords long |
| hdr_valid | output | 1 | Header offered |
| hdr_ready | input | 1 | Header taken |
| out_data | output | 256 | Realigned payload beat |
| out_sop | output | 1 | First payload beat |
| out_eop | output | 1 | Last payload beat |
| out_empty | output | 3 | Unused dwords on the last beat |
| out_valid | output | 1 | Payload beat offered |
| out_ready | input | 1 | Payload beat taken |

## Verification
The assertions assume an input stream that agrees with its own headers. in_eop must fall on the beat holding the last payload dword implied by the length field and the start offset, and in_empty must count the whole unused dword pairs above it. in_sop must appear only on the first beat of a packet. The bench builds every packet from header size, address bit, length and base value, so end, empty and padding follow the same rule. It sends junk beats only while no packet is open.

// File: rtl/tlp_rx_realign.sv
module tlp_rx_realign (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [255:0] in_data,
  input  logic         in_sop,
  input  logic         in_eop,
  input  logic [1:0]   in_empty,
  input  logic         in_valid,
  output logic         in_ready,
  output logic [127:0] hdr_data,
  output logic         hdr_4dw,
  output logic         hdr_valid,
  input  logic         hdr_ready,
  output logic [255:0] out_data,
  output logic         out_sop,
  output logic         out_eop,
  output logic [2:0]   out_empty,
  output logic         out_valid,
  input  logic         out_ready
);
  localparam int DW    = 32;
  localparam int LANES = 8;
  localparam int BUS   = DW * LANES;
  localparam int LW    = 11;

  typedef enum logic [1:0] {S_IDLE, S_BODY, S_FLUSH} st_t;

  st_t           st;
  logic [BUS-1:0] hold;
  logic [2:0]     sft;
  logic [LW-1:0]  rem;
  logic           first;

  logic           h_fmt4, h_a2;
  logic [2:0]     h_sft;
  logic [LW-1:0]  h_len, h_room, room, rem_after;
  logic           can_emit, in_fire, pkt_start, emit, last;
  logic [BUS-1:0] shifted, nxt_data;
  logic [2:0]     nxt_empty;

  assign h_fmt4 = in_data[29];
  assign h_a2   = h_fmt4 ? in_data[3*DW+2] : in_data[2*DW+2];
  assign h_sft  = h_fmt4 ? (h_a2 ? 3'd5 : 3'd4) : (h_a2 ? 3'd3 : 3'd4);
  assign h_len  = (in_data[9:0] == 10'd0) ? 11'd1024 : {1'b0, in_data[9:0]};
  assign h_room = 11'd8 - {8'd0, h_sft};
  assign room   = 11'd8 - {8'd0, sft};

  assign can_emit  = (!out_valid || out_ready) && !hdr_valid;
  assign in_ready  = (st == S_IDLE) ? !hdr_valid : ((st == S_BODY) && can_emit);
  assign in_fire   = in_valid && in_ready;
  assign pkt_start = in_fire && in_sop && (st == S_IDLE);
  assign emit      = ((st == S_BODY) && in_fire) || ((st == S_FLUSH) && can_emit);
  assign last      = rem <= 11'd8;
  assign rem_after = last ? '0 : rem - 11'd8;

  assign shifted = BUS'({(st == S_FLUSH) ? {BUS{1'b0}} : in_data, hold} >> (DW * sft));

  always_comb begin
    nxt_data = shifted;
    for (int i = 0; i < LANES; i++)
      if (last && (LW'(i) >= rem)) nxt_data[i*DW +: DW] = '0;
  end

  assign nxt_empty = last ? 3'(4'd8 - rem[3:0]) : 3'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      hold      <= '0;
      sft       <= 3'd4;
      rem       <= '0;
      first     <= 1'b0;
      hdr_valid <= 1'b0;
      hdr_data  <= '0;
      hdr_4dw   <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_empty <= '0;
    end else begin
      if (pkt_start) begin
        hdr_valid <= 1'b1;
        hdr_data  <= {h_fmt4 ? in_data[4*DW-1:3*DW] : 32'd0, in_data[3*DW-1:0]};
        hdr_4dw   <= h_fmt4;
      end else if (hdr_ready) begin
        hdr_valid <= 1'b0;
      end

      if (emit) begin
        out_valid <= 1'b1;
        out_data  <= nxt_data;
        out_sop   <= first;
        out_eop   <= last;
        out_empty <= nxt_empty;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end

      case (st)
        S_IDLE: if (pkt_start) begin
          hold  <= in_data;
          sft   <= h_sft;
          rem   <= h_len;
          first <= 1'b1;
          st    <= (h_len <= h_room) ? S_FLUSH : S_BODY;
        end
        S_BODY: if (in_fire) begin
          hold  <= in_data;
          rem   <= rem_after;
          first <= 1'b0;
          st    <= (rem_after == '0) ? S_IDLE : ((rem_after <= room) ? S_FLUSH : S_BODY);
        end
        S_FLUSH: if (can_emit) begin
          rem   <= '0;
          first <= 1'b0;
          st    <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [LW-1:0] used;
  logic [1:0]    exp_qw;
  assign used   = (st == S_IDLE) ? (h_len + {8'd0, h_sft}) : (rem + {8'd0, sft} - 11'd8);
  assign exp_qw = 2'((11'd8 - used) >> 1);

  a_r1_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_eop) && $stable(out_empty));

  a_r2_hdr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && !hdr_ready |=> hdr_valid && $stable(hdr_data) && $stable(hdr_4dw));

  a_r3_idle_no_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> !hdr_valid);

  a_r6_rem_live: assert property (@(posedge clk) disable iff (!rst_n)
    st != S_IDLE |-> rem != '0);

  a_r6_eop_agrees: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && ((st == S_BODY) || in_sop) |-> in_eop == (used <= 11'd8));

  a_r6_empty_agrees: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && in_eop && ((st == S_BODY) || in_sop) |-> in_empty == exp_qw);

  a_r7_empty_eop: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_eop |-> out_empty == 3'd0);
endmodule

// File: tb/test_tlp_rx_realign.sv
module test_tlp_rx_realign;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n;
  logic [255:0] in_data;
  logic         in_sop, in_eop, in_valid, in_ready;
  logic [1:0]   in_empty;
  logic [127:0] hdr_data;
  logic         hdr_4dw, hdr_valid, hdr_ready;
  logic [255:0] out_data;
  logic         out_sop, out_eop, out_valid, out_ready;
  logic [2:0]   out_empty;

  tlp_rx_realign i_tlp_rx_realign (
    .clk(clk), .rst_n(rst_n),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty),
    .in_valid(in_valid), .in_ready(in_ready),
    .hdr_data(hdr_data), .hdr_4dw(hdr_4dw), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop), .out_empty(out_empty),
    .out_valid(out_valid), .out_ready(out_ready)
  );

  int total = 0;
  int bad   = 0;
  int wd    = 0;

  logic [255:0] qd[$];
  logic         qs[$];
  logic         qe[$];
  logic [1:0]   qm[$];
  logic [260:0] ex[$];
  string        et[$];
  logic [128:0] eh[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [299:0] act, input logic [299:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      bad++;
      total++;
      $display("FAIL R1 watchdog act=%0d exp=%0d", wd, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic add_pkt(input bit f4, input bit a2, input int len,
                         input logic [31:0] base, input string tag);
    int s, tot, nin, nout, used, idx, emp;
    logic [31:0] w[$];
    logic [255:0] d;
    logic [1:0] m;
    s    = f4 ? (a2 ? 5 : 4) : (a2 ? 3 : 4);
    tot  = s + len;
    nin  = (tot + 7) / 8;
    nout = (len + 7) / 8;
    for (int j = 0; j < nin * 8; j++) w.push_back(32'hBAD0_0000 + 32'(j));
    w[0] = (f4 ? 32'h2000_0000 : 32'h0) | 32'h0A00_0000 | 32'(len % 1024);
    w[1] = 32'h1111_0000 + base;
    if (f4) begin
      w[2] = 32'h2220_0000 | {29'd0, !a2, 2'd0};
      w[3] = 32'h3330_0000 | {29'd0, a2, 2'd0};
      if (a2) w[4] = 32'h6A90_0000;
    end else begin
      w[2] = 32'h2220_0000 | {29'd0, a2, 2'd0};
      if (!a2) w[3] = 32'h6A90_0000;
    end
    for (int i = 0; i < len; i++) w[s+i] = base + 32'(i);
    for (int b = 0; b < nin; b++) begin
      for (int i = 0; i < 8; i++) d[i*32 +: 32] = w[b*8+i];
      used = tot - 8 * (nin - 1);
      m = (b == nin - 1) ? 2'((8 - used) / 2) : 2'd0;
      qd.push_back(d); qs.push_back(b == 0); qe.push_back(b == nin - 1); qm.push_back(m);
    end
    for (int k = 0; k < nout; k++) begin
      for (int i = 0; i < 8; i++) begin
        idx = 8 * k + i;
        d[i*32 +: 32] = (idx < len) ? base + 32'(idx) : 32'd0;
      end
      emp = (k == nout - 1) ? 8 * nout - len : 0;
      ex.push_back({k == 0, k == nout - 1, 3'(emp), d});
      et.push_back(tag);
    end
    eh.push_back({f4, f4 ? w[3] : 32'd0, w[2], w[1], w[0]});
  endtask

  task automatic add_junk(input int n);
    for (int j = 0; j < n; j++) begin
      qd.push_back({8{32'h2000_0005 + 32'(j)}});
      qs.push_back(1'b0); qe.push_back(j[0]); qm.push_back(2'd1);
    end
  endtask

  task automatic run(input int omode, input int hhold, input string tag);
    int cyc, stalls, early;
    bit ph;
    logic [255:0] pdata;
    cyc = 0; stalls = 0; early = 0; ph = 0; pdata = '0;
    while ((qd.size() > 0 || ex.size() > 0 || eh.size() > 0) && cyc < 20000) begin
      @(negedge clk);
      if (ph) chk(out_valid && out_data == pdata, "R1", "held output",
                  {out_valid, out_data}, {1'b1, pdata});
      in_valid = qd.size() > 0;
      if (in_valid) begin
        in_data = qd[0]; in_sop = qs[0]; in_eop = qe[0]; in_empty = qm[0];
      end else begin
        in_data = '0; in_sop = 0; in_eop = 0; in_empty = 0;
      end
      out_ready = (omode == 0) ? 1'b1 : (omode == 1) ? (cyc % 3 != 1) : (cyc >= 12);
      hdr_ready = cyc >= hhold;
      #1;
      if (in_valid && !in_ready) stalls++;
      if (cyc < hhold && out_valid) early++;
      if (in_valid && in_ready) begin
        void'(qd.pop_front()); void'(qs.pop_front()); void'(qe.pop_front()); void'(qm.pop_front());
      end
      if (hdr_valid && hdr_ready) begin
        if (eh.size() == 0) chk(0, "R2", "spurious header", {hdr_4dw, hdr_data}, 0);
        else begin
          chk({hdr_4dw, hdr_data} == eh[0], "R2", "header", {hdr_4dw, hdr_data}, eh[0]);
          void'(eh.pop_front());
        end
      end
      if (out_valid && out_ready) begin
        if (ex.size() == 0) chk(0, "R10", "spurious payload beat", out_data, 0);
        else begin
          chk({out_sop, out_eop, out_empty, out_data} == ex[0], et[0], "payload beat",
              {out_sop, out_eop, out_empty, out_data}, ex[0]);
          void'(ex.pop_front()); void'(et.pop_front());
        end
      end
      ph = out_valid && !out_ready;
      pdata = out_data;
      cyc++;
    end
    in_valid = 0; out_ready = 1; hdr_ready = 1;
    chk(cyc < 20000, tag, "run completes", cyc, 20000);
    if (hhold > 0) chk(early == 0, "R3", "payload before header", early, 0);
    if (omode == 2) chk(stalls > 0, "R11", "input stalled under backpressure", stalls, 1);
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid && !hdr_valid, tag, "no extra beat", {out_valid, hdr_valid}, 0);
  endtask

  task automatic t_reset();
    rst_n = 0; in_valid = 0; in_data = '0; in_sop = 0; in_eop = 0; in_empty = 0;
    out_ready = 1; hdr_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(!out_valid && !hdr_valid && in_ready, "R12", "reset state",
        {out_valid, hdr_valid, in_ready}, 3'b001);
  endtask

  task automatic t_offsets();
    add_pkt(0, 0, 3, 32'h100, "R4");
    add_pkt(0, 1, 5, 32'h200, "R9");
    add_pkt(1, 0, 2, 32'h300, "R4");
    add_pkt(1, 1, 9, 32'h400, "R4");
    run(0, 0, "R4");
  endtask

  task automatic t_carry();
    add_pkt(0, 1, 12, 32'h1000, "R8");
    add_pkt(1, 1, 20, 32'h2000, "R5");
    add_pkt(0, 0, 16, 32'h3000, "R5");
    add_pkt(1, 0, 7, 32'h4000, "R7");
    run(0, 0, "R5");
  endtask

  task automatic t_long();
    add_pkt(1, 0, 1024, 32'h1_0000, "R6");
    add_pkt(0, 1, 1023, 32'h2_0000, "R6");
    run(1, 0, "R6");
  endtask

  task automatic t_hdr_first();
    add_pkt(1, 1, 30, 32'h5000, "R3");
    run(0, 10, "R3");
  endtask

  task automatic t_backpressure();
    add_pkt(0, 0, 40, 32'h7000, "R11");
    add_pkt(1, 1, 13, 32'h8000, "R11");
    run(2, 0, "R11");
  endtask

  task automatic t_junk();
    add_junk(3);
    add_pkt(0, 0, 10, 32'h6000, "R10");
    run(0, 0, "R10");
  endtask

  initial begin
    t_reset();
    t_offsets();
    t_carry();
    t_long();
    t_hdr_first();
    t_backpressure();
    t_junk();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule